// File: doc/BRIEF.md
# Vectored priority interrupt arbiter

This block sits beside a processor core and decides which device interrupt the core services next. Each of `NUM_SRC` sources is bound at build time to one of eight priority levels, to a trigger style (edge or level), and to a vector equal to `VEC_BASE + VEC_STEP * s`, where `s` is the source index. Requests wait in a small first-come queue kept for each level. The block holds the 3-bit processor priority. A set-priority instruction or a write of the status word changes it.

The core raises `insn_boundary` before it executes each instruction. On such a cycle, or on any cycle while the core sleeps in the wait state, the block looks for the highest level above the processor priority whose queue is not empty. If it finds one, it pulses `take_o` and presents the vector and a one-hot acknowledge for the head source. In the same step it wakes the core from waiting. An edge-style source then leaves its queue. A level-style source stays queued until its device drops the request. The core itself does the trap entry.

Top module: `irq_arbiter`

## Requirements
- R1: `prio_o` loads `psw_data[7:5]` when `psw_wr` is high. Otherwise, when `spl_valid` is high and `spl_opcode[7:3]` is 5'b10011 (opcodes 0x98 to 0x9F), it loads `spl_opcode[2:0]`. Any other opcode leaves it unchanged.
- R2: A queued request is taken only if its level is strictly greater than `prio_o`. A level-7 request is taken whenever `prio_o` is 6 or lower.
- R3: When several levels hold eligible requests, the highest level wins.
- R4: Within one level, sources are served in the order their requests rose. A request that rises again while its source is still queued adds no second entry.
- R5: A level-style source stays queued after it is acknowledged. When its `src_req` goes low, it is removed from any position in its queue.
- R6: An edge-style source is queued on a rising edge of its `src_req` and is removed when it is acknowledged.
- R7: A scan runs on a cycle where `insn_boundary` is high or the state is wait, and the state is not halt and `halt_req` is low. A scan takes at most one request. `take_o`, `vec_o` and the one-hot `ack_o` change on the same clock edge, one edge after the scan. `vec_o` and `ack_o` are zero when `take_o` is low.
- R8: `state_o` encodes run=0, wait=1, halt=2. `halt_req` enters halt. In halt, `run_req` returns to run and no request is taken. A take returns the state to run. Otherwise `wait_req` enters wait.
- R9: A level queue holds `QDEPTH` sources. A new request into a full queue is dropped and sets bit L of the sticky `ovf_o`, where L is the level.
- R10: Synchronous reset clears `take_o`, `ack_o`, `vec_o`, `prio_o`, `ovf_o` and all queues, and sets the state to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Request line of each source |
| insn_boundary | input | 1 | Core is about to start an instruction |
| spl_valid | input | 1 | `spl_opcode` holds an executed opcode |
| spl_opcode | input | 8 | Low opcode byte, decoded for set-priority |
| psw_wr | input | 1 | Status word is being written |
| psw_data | input | 16 | Status word value |
| wait_req | input | 1 | Core executes a wait-for-interrupt |
| halt_req | input | 1 | Core halts |
| run_req | input | 1 | Resume from halt |
| take_o | output | 1 | Take-interrupt pulse |
| vec_o | output | VEC_W | Vector of the taken source |
| ack_o | output | NUM_SRC | One-hot acknowledge to the taken source |
| prio_o | output | 3 | Current processor priority |
| state_o | output | 2 | Run state of the core |
| ovf_o | output | 8 | Sticky queue overflow flag per level |

## Verification
The hardest case to reach is a queue with a hole and an arrival in the same stretch: a level source sits between two edge sources, drops its request, and the rest must keep their order. The bench holds `insn_boundary` low while it builds queues one pulse at a time, so the queue contents are fully known. It then releases boundary pulses one at a time, so each pulse yields a single take that the scoreboard can match. The same trick fills a level queue past its depth, and it leaves a request waiting when the core halts or waits.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_LVL = 8;
  localparam int LVL_W   = 3;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_HALT = 2'd2
  } run_st_t;

  // set-priority opcodes occupy 0x98..0x9F
  function automatic logic is_set_prio(input logic [7:0] op);
    return op[7:3] == 5'b10011;
  endfunction
endpackage

// File: rtl/irq_level_queue.sv
module irq_level_queue #(
  parameter int NUM_SRC = 8,
  parameter int DEPTH   = 4,
  localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] arrive,
  input  logic [NUM_SRC-1:0] gone,
  input  logic               pop,
  output logic [SW-1:0]      head,
  output logic               nonempty,
  output logic               ovf_pulse
);
  logic [SW-1:0] slot_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] kept   [DEPTH];
  logic [SW-1:0] nxt    [DEPTH];
  logic [CW-1:0] cnt_d;

  always_comb begin
    int  k;
    logic dup;
    k = 0;
    dup = 1'b0;
    ovf_pulse = 1'b0;
    for (int i = 0; i < DEPTH; i++) kept[i] = '0;
    // squeeze out level sources whose request fell, keeping order
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(cnt_q) && !gone[slot_q[i]]) begin
        kept[AW'(k)] = slot_q[i];
        k++;
      end
    end
    head     = kept[0];
    nonempty = (k != 0);
    for (int i = 0; i < DEPTH; i++) nxt[i] = kept[i];
    // acknowledged edge source leaves from the front
    if (pop && k > 0) begin
      for (int i = 0; i < DEPTH - 1; i++) nxt[i] = kept[i + 1];
      nxt[DEPTH-1] = '0;
      k--;
    end
    // append new arrivals in index order, unique only
    for (int s = 0; s < NUM_SRC; s++) begin
      if (arrive[s]) begin
        dup = 1'b0;
        for (int i = 0; i < DEPTH; i++)
          if (i < k && nxt[i] == SW'(s)) dup = 1'b1;
        if (!dup) begin
          if (k < DEPTH) begin
            nxt[AW'(k)] = SW'(s);
            k++;
          end else begin
            ovf_pulse = 1'b1;
          end
        end
      end
    end
    cnt_d = CW'(k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_pkg::*;
(
  input  logic [NUM_LVL-1:0] nonempty,
  input  logic [LVL_W-1:0]   prio,
  output logic               found,
  output logic [LVL_W-1:0]   lvl
);
  always_comb begin
    found = 1'b0;
    lvl   = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (!found && nonempty[l] && LVL_W'(l) > prio) begin
        found = 1'b1;
        lvl   = LVL_W'(l);
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int QDEPTH   = 4,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 'h30,
  parameter int VEC_STEP = 4,
  parameter logic [NUM_SRC*LVL_W-1:0] SRC_PRIO =
    {3'd2, 3'd5, 3'd7, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4},
  parameter logic [NUM_SRC-1:0] SRC_EDGE = 8'b1011_1011,
  localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               insn_boundary,
  input  logic               spl_valid,
  input  logic [7:0]         spl_opcode,
  input  logic               psw_wr,
  input  logic [15:0]        psw_data,
  input  logic               wait_req,
  input  logic               halt_req,
  input  logic               run_req,
  output logic               take_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [NUM_SRC-1:0] ack_o,
  output logic [LVL_W-1:0]   prio_o,
  output logic [1:0]         state_o,
  output logic [NUM_LVL-1:0] ovf_o
);
  run_st_t              state_q;
  logic [NUM_SRC-1:0]   req_q;
  logic [NUM_SRC-1:0]   rise;
  logic [NUM_SRC-1:0]   gone;
  logic [NUM_SRC-1:0]   lvl_mask [NUM_LVL];
  logic [SW-1:0]        heads    [NUM_LVL];
  logic [NUM_LVL-1:0]   nonempty;
  logic [NUM_LVL-1:0]   ovf_pulse;
  logic [NUM_LVL-1:0]   pop;
  logic                 found;
  logic [LVL_W-1:0]     win_lvl;
  logic [SW-1:0]        win_src;
  logic                 scan;
  logic                 fire;

  assign rise = src_req & ~req_q;
  assign gone = ~SRC_EDGE & ~src_req;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign lvl_mask[l][s] = (SRC_PRIO[s*LVL_W +: LVL_W] == LVL_W'(l));
    end
    assign pop[l] = fire && (win_lvl == LVL_W'(l)) && SRC_EDGE[heads[l]];
    irq_level_queue #(.NUM_SRC(NUM_SRC), .DEPTH(QDEPTH)) u_q (
      .clk       (clk),
      .rst       (rst),
      .arrive    (rise & lvl_mask[l]),
      .gone      (gone),
      .pop       (pop[l]),
      .head      (heads[l]),
      .nonempty  (nonempty[l]),
      .ovf_pulse (ovf_pulse[l])
    );
  end

  irq_prio_pick u_pick (
    .nonempty (nonempty),
    .prio     (prio_o),
    .found    (found),
    .lvl      (win_lvl)
  );

  assign win_src = heads[win_lvl];
  assign scan    = (state_q != ST_HALT) && !halt_req &&
                   (insn_boundary || state_q == ST_WAIT);
  assign fire    = scan && found;
  assign state_o = state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= '0;
      take_o  <= 1'b0;
      vec_o   <= '0;
      ack_o   <= '0;
      prio_o  <= '0;
      ovf_o   <= '0;
      state_q <= ST_RUN;
    end else begin
      req_q  <= src_req;
      take_o <= fire;
      ack_o  <= fire ? (NUM_SRC'(1) << win_src) : '0;
      vec_o  <= fire ? VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(win_src) : '0;
      ovf_o  <= ovf_o | ovf_pulse;
      if (psw_wr)
        prio_o <= psw_data[7:5];
      else if (spl_valid && is_set_prio(spl_opcode))
        prio_o <= spl_opcode[2:0];
      if (halt_req)
        state_q <= ST_HALT;
      else if (state_q == ST_HALT) begin
        if (run_req) state_q <= ST_RUN;
      end else if (fire)
        state_q <= ST_RUN;
      else if (wait_req)
        state_q <= ST_WAIT;
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC*LVL_W-1:0] SRC_PRIO = '0
) (
  input logic               clk,
  input logic               rst,
  input logic               spl_valid,
  input logic [7:0]         spl_opcode,
  input logic               psw_wr,
  input logic               take_o,
  input logic [NUM_SRC-1:0] ack_o,
  input logic [LVL_W-1:0]   prio_o,
  input logic [1:0]         state_o,
  input logic [NUM_LVL-1:0] ovf_o
);
  logic [LVL_W-1:0] ack_lvl;
  always_comb begin
    ack_lvl = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (ack_o[s]) ack_lvl = SRC_PRIO[s*LVL_W +: LVL_W];
  end

  p_ack_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $countones(ack_o) == 1);
  p_ack_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> ack_o == '0);
  p_take_above_prio_r2: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ack_lvl > $past(prio_o));
  p_take_wakes_r8: assert property (@(posedge clk) disable iff (rst)
    take_o |-> state_o == 2'd0);
  p_no_take_halted_r8: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(state_o) != 2'd2);
  p_spl_load_r1: assert property (@(posedge clk) disable iff (rst)
    (spl_valid && spl_opcode[7:3] == 5'b10011 && !psw_wr) |=> prio_o == $past(spl_opcode[2:0]));
  p_prio_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!spl_valid && !psw_wr) |=> $stable(prio_o));
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_o & $past(ovf_o)) == $past(ovf_o));
endmodule

bind irq_arbiter irq_arbiter_chk #(.NUM_SRC(NUM_SRC), .SRC_PRIO(SRC_PRIO)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .spl_valid  (spl_valid),
  .spl_opcode (spl_opcode),
  .psw_wr     (psw_wr),
  .take_o     (take_o),
  .ack_o      (ack_o),
  .prio_o     (prio_o),
  .state_o    (state_o),
  .ovf_o      (ovf_o)
);

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;

  typedef struct {
    int    src;
    string tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_req = '0;
  logic            insn_boundary = 1'b0;
  logic            spl_valid = 1'b0;
  logic [7:0]      spl_opcode = '0;
  logic            psw_wr = 1'b0;
  logic [15:0]     psw_data = '0;
  logic            wait_req = 1'b0;
  logic            halt_req = 1'b0;
  logic            run_req = 1'b0;
  logic            take_o;
  logic [15:0]     vec_o;
  logic [NSRC-1:0] ack_o;
  logic [2:0]      prio_o;
  logic [1:0]      state_o;
  logic [7:0]      ovf_o;

  int   checks = 0;
  int   errors = 0;
  exp_t exp_q[$];

  irq_arbiter dut (
    .clk(clk), .rst(rst), .src_req(src_req), .insn_boundary(insn_boundary),
    .spl_valid(spl_valid), .spl_opcode(spl_opcode), .psw_wr(psw_wr),
    .psw_data(psw_data), .wait_req(wait_req), .halt_req(halt_req),
    .run_req(run_req), .take_o(take_o), .vec_o(vec_o), .ack_o(ack_o),
    .prio_o(prio_o), .state_o(state_o), .ovf_o(ovf_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int vec_of(int s);
    return 'h30 + 4 * s;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && take_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected take", int'(vec_o), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(vec_o == 16'(vec_of(e.src)), {e.tag, " vector"}, int'(vec_o), vec_of(e.src));
        check(ack_o == NSRC'(1 << e.src), {e.tag, " ack"}, int'(ack_o), 1 << e.src);
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_take(int s, string tag);
    exp_t e;
    e.src = s;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic pulse_src(int s);
    @(negedge clk) src_req[s] = 1'b1;
    @(negedge clk) src_req[s] = 1'b0;
  endtask

  task automatic bpulse(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) insn_boundary = 1'b1;
      @(negedge clk) insn_boundary = 1'b0;
      tick(2);
    end
  endtask

  task automatic set_spl(logic [7:0] op);
    @(negedge clk) begin spl_valid = 1'b1; spl_opcode = op; end
    @(negedge clk) spl_valid = 1'b0;
  endtask

  task automatic set_psw(logic [15:0] v);
    @(negedge clk) begin psw_wr = 1'b1; psw_data = v; end
    @(negedge clk) psw_wr = 1'b0;
  endtask

  task automatic drained(string tag);
    tick(2);
    check(exp_q.size() == 0, {tag, " pending expected takes"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    tick(4);
    @(negedge clk) rst = 1'b0;
    // R10 reset state
    check(take_o == 1'b0 && ack_o == '0 && vec_o == '0, "R10 outputs idle", int'(ack_o), 0);
    check(prio_o == 3'd0, "R10 prio", prio_o, 0);
    check(state_o == 2'd0, "R10 state", state_o, 0);
    check(ovf_o == 8'h00, "R10 ovf", ovf_o, 0);

    // R1 priority loads
    set_spl(8'h9D);
    check(prio_o == 3'd5, "R1 spl load", prio_o, 5);
    set_spl(8'hA5);
    check(prio_o == 3'd5, "R1 non-spl ignored", prio_o, 5);
    set_psw(16'h00E0);
    check(prio_o == 3'd7, "R1 psw load", prio_o, 7);
    @(negedge clk) begin psw_wr = 1'b1; psw_data = 16'h00A0; spl_valid = 1'b1; spl_opcode = 8'h9A; end
    @(negedge clk) begin psw_wr = 1'b0; spl_valid = 1'b0; end
    check(prio_o == 3'd5, "R1 psw over spl", prio_o, 5);
    set_psw(16'h0000);
    check(prio_o == 3'd0, "R1 psw clear", prio_o, 0);

    // R4 order within a level, R6 edge sources leave on ack
    pulse_src(1);
    pulse_src(0);
    expect_take(1, "R4 first arrival");
    expect_take(0, "R4 second arrival");
    bpulse(3);
    drained("R6");

    // R3 highest level first, R5 level source stays after ack
    pulse_src(7);
    @(negedge clk) src_req[6] = 1'b1;
    pulse_src(5);
    expect_take(5, "R3 level7");
    expect_take(6, "R3 level5");
    expect_take(6, "R5 level stays");
    bpulse(3);
    @(negedge clk) src_req[6] = 1'b0;
    expect_take(7, "R3 level2");
    bpulse(2);
    drained("R5");

    // R2 threshold
    set_spl(8'h9C);
    pulse_src(0);
    pulse_src(7);
    bpulse(1);
    drained("R2 equal level not taken");
    set_spl(8'h9B);
    expect_take(0, "R2 above prio");
    bpulse(1);
    drained("R2");
    set_spl(8'h9E);
    pulse_src(5);
    expect_take(5, "R2 level7 over prio6");
    bpulse(1);
    drained("R2 level7");
    set_psw(16'h0000);
    expect_take(7, "R2 after prio drop");
    bpulse(2);
    drained("R2 low");

    // R5 removal from the middle
    pulse_src(0);
    @(negedge clk) src_req[2] = 1'b1;
    pulse_src(1);
    @(negedge clk) src_req[2] = 1'b0;
    expect_take(0, "R5 head kept");
    expect_take(1, "R5 tail kept");
    bpulse(3);
    drained("R5 middle removal");

    // R4 duplicate suppressed
    pulse_src(3);
    pulse_src(3);
    pulse_src(4);
    expect_take(3, "R4 dedup");
    expect_take(4, "R4 after dedup");
    bpulse(3);
    drained("R4 dedup");

    // R9 overflow
    pulse_src(0);
    pulse_src(1);
    pulse_src(3);
    pulse_src(4);
    @(negedge clk) src_req[2] = 1'b1;
    tick(2);
    check(ovf_o == 8'h10, "R9 overflow flag", ovf_o, 'h10);
    expect_take(0, "R9 q0");
    expect_take(1, "R9 q1");
    expect_take(3, "R9 q2");
    expect_take(4, "R9 q3");
    bpulse(5);
    drained("R9 dropped source");
    @(negedge clk) src_req[2] = 1'b0;
    tick(2);
    check(ovf_o == 8'h10, "R9 sticky", ovf_o, 'h10);

    // R8 wait state woken by take without boundary
    @(negedge clk) wait_req = 1'b1;
    @(negedge clk) wait_req = 1'b0;
    check(state_o == 2'd1, "R8 enter wait", state_o, 1);
    expect_take(7, "R8 wake take");
    pulse_src(7);
    tick(3);
    check(state_o == 2'd0, "R8 woken", state_o, 0);
    drained("R8 wait");

    // R8 halt blocks takes
    @(negedge clk) halt_req = 1'b1;
    @(negedge clk) halt_req = 1'b0;
    check(state_o == 2'd2, "R8 enter halt", state_o, 2);
    pulse_src(0);
    bpulse(2);
    drained("R8 halted no take");
    check(state_o == 2'd2, "R8 still halted", state_o, 2);
    @(negedge clk) run_req = 1'b1;
    @(negedge clk) run_req = 1'b0;
    check(state_o == 2'd0, "R8 resume", state_o, 0);
    expect_take(0, "R7 take after resume");
    bpulse(2);
    drained("R7");

    finish_run();
  end
endmodule